// File: doc/BRIEF.md
# Four-Phase Dual-Rail Adiabatic Pipeline

This block is a cycle-accurate digital model of a two-level adiabatic shift pipeline. A small tick counter cycles through four ticks. From it the block derives four overlapping timing phases, each high for two consecutive ticks. A chain of buffer stages carries every bit as a pulse on one of two complementary rails. Stage k belongs to phase k mod 4. A stage picks up its predecessor's pulse when its phase rises, keeps it while the phase stays high, and drops back to the empty state when the phase falls. A value therefore advances exactly one stage per tick.

A dual-rail logic element sits at the head of the chain. It combines two rail-coded operands with a non-inverting AND or OR built only from the rails. Every inversion, on either operand or on the result, is a rail swap and costs no gate. The source is sampled once per four-tick cycle, during the tick that comes just before stage 0's phase opens. The result then travels the chain as a wave. A new operand pair can start a wave every four ticks.

Rail coding is (r1, r0): (1,0) is logic 1, (0,1) is logic 0, (0,0) carries no data, and (1,1) is illegal.

Top module: `adiabatic_pipe`

## Requirements
- R1: A synchronous reset puts the tick counter at 0, empties every stage, so that the output rails read (0,0), and clears the error flag.
- R2: Outside reset the tick output steps 0,1,2,3,0,… once per clock. Phase i (bit i of `phase`) is high exactly during ticks i and (i+1) mod 4, so two phases are always high.
- R3: The operand rails and controls are sampled only at the clock edge that ends tick 3. Values presented during ticks 0, 1 and 2 have no effect on the output rails or on the error flag.
- R4: A result sampled at the end of cycle c appears on `yR1`/`yR0` during cycles c+STAGES and c+STAGES+1 (counted in clocks), and the output is (0,0) in every cycle that carries no wave.
- R5: With `opSel`=0 the result is the AND of the operands, and with `opSel`=1 it is their OR.
- R6: `invA`, `invB` and `invY` each swap the rails of the first operand, the second operand or the result, which inverts its logic value.
- R7: If either operand is (0,0), the result wave is (0,0).
- R8: If either sampled operand is (1,1), `errFlag` is high for exactly the one cycle after the sampling edge and the result wave is (0,0). No stage ever holds (1,1).
- R9: Waves started on consecutive four-tick cycles reach the output in order, with none lost or merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick per cycle |
| rst | input | 1 | Synchronous reset, active high |
| aR1 | input | 1 | First operand, true rail |
| aR0 | input | 1 | First operand, false rail |
| bR1 | input | 1 | Second operand, true rail |
| bR0 | input | 1 | Second operand, false rail |
| opSel | input | 1 | 0 selects AND, 1 selects OR |
| invA | input | 1 | Swap rails of first operand |
| invB | input | 1 | Swap rails of second operand |
| invY | input | 1 | Swap rails of the result |
| tick | output | 2 | Current tick within the four-tick cycle |
| phase | output | 4 | The four overlapping timing phases |
| yR1 | output | 1 | Last stage, true rail |
| yR0 | output | 1 | Last stage, false rail |
| errFlag | output | 1 | One-cycle pulse after an illegal operand is sampled |

## Verification
The tick and phase outputs are due in the same cycle as the counter state, so they are compared every cycle against the cycle count taken since reset. An operand pair sampled at the end of cycle c owes its result in cycles c+STAGES and c+STAGES+1, and an illegal pair owes its error pulse in cycle c+1. The bench writes these into a ring of expected values at the moment it drives the stimulus. One cycle later it samples the outputs at the falling edge and compares them with the ring slot for that cycle, and every slot without a wave must read (0,0). Stimulus in the three ignored ticks is random, including illegal pairs, so a design that samples at the wrong tick disturbs a slot that must stay empty.

// File: rtl/adp_pkg.sv
package adp_pkg;
  localparam int unsigned NUM_PHASES = 4;
  localparam int unsigned TICK_W = $clog2(NUM_PHASES);

  typedef struct packed {
    logic r1;
    logic r0;
  } rail_t;

  localparam rail_t RAIL_NULL = '{r1: 1'b0, r0: 1'b0};

  typedef enum logic {
    OP_AND = 1'b0,
    OP_OR  = 1'b1
  } gateOp_t;

  // strobes for the coming edge: load when the phase rises, hold while it stays high
  typedef struct packed {
    logic [NUM_PHASES-1:0] loadEn;
    logic [NUM_PHASES-1:0] holdEn;
  } phaseStrobe_t;
endpackage

// File: rtl/adp_phase_ctrl.sv
module adp_phase_ctrl
  import adp_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  output logic [TICK_W-1:0]     tick,
  output logic [NUM_PHASES-1:0] phase,
  output phaseStrobe_t          strobe
);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(NUM_PHASES - 1);

  logic [NUM_PHASES-1:0] loadVec;
  logic [NUM_PHASES-1:0] holdVec;

  always_ff @(posedge clk) begin
    if (rst) tick <= '0;
    else if (tick == LAST_TICK) tick <= '0;
    else tick <= tick + 1'b1;
  end

  for (genvar i = 0; i < NUM_PHASES; i++) begin : g_phase
    localparam int unsigned NEXT = (i + 1) % NUM_PHASES;
    localparam int unsigned PREV = (i + NUM_PHASES - 1) % NUM_PHASES;
    assign phase[i]   = (tick == TICK_W'(i)) || (tick == TICK_W'(NEXT));
    assign loadVec[i] = (tick == TICK_W'(PREV));
    assign holdVec[i] = (tick == TICK_W'(i));
  end

  assign strobe = '{loadEn: loadVec, holdEn: holdVec};

  // R2: the counter steps by one and wraps
  p_tick_step_r2 : assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tick == (($past(tick) == LAST_TICK) ? '0 : $past(tick) + 1'b1));
  // R2: exactly two overlapping phases are high at every tick
  p_two_phases_r2 : assert property (@(posedge clk) disable iff (rst)
    $countones(phase) == 2);
  // R2: one phase rises at each edge, and it is low before that edge
  p_one_rise_r2 : assert property (@(posedge clk) disable iff (rst)
    $countones(strobe.loadEn) == 1 && (strobe.loadEn & phase) == '0);
endmodule

// File: rtl/adp_rail_gate.sv
module adp_rail_gate
  import adp_pkg::*;
(
  input  rail_t   opA,
  input  rail_t   opB,
  input  gateOp_t op,
  input  logic    swapA,
  input  logic    swapB,
  input  logic    swapY,
  output rail_t   result,
  output logic    illegal
);
  rail_t railA;
  rail_t railB;
  rail_t core;
  logic  bothValid;

  // inversion costs nothing: just exchange the rails
  assign railA = swapA ? '{r1: opA.r0, r0: opA.r1} : opA;
  assign railB = swapB ? '{r1: opB.r0, r0: opB.r1} : opB;

  assign illegal   = (opA.r1 & opA.r0) | (opB.r1 & opB.r0);
  assign bothValid = (opA.r1 ^ opA.r0) & (opB.r1 ^ opB.r0);

  always_comb begin
    core = RAIL_NULL;
    if (bothValid) begin
      if (op == OP_AND) begin
        core.r1 = railA.r1 & railB.r1;
        core.r0 = railA.r0 | railB.r0;
      end else begin
        core.r1 = railA.r1 | railB.r1;
        core.r0 = railA.r0 & railB.r0;
      end
    end
  end

  assign result = swapY ? '{r1: core.r0, r0: core.r1} : core;
endmodule

// File: rtl/adp_datapath.sv
module adp_datapath
  import adp_pkg::*;
#(
  parameter int unsigned STAGES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  phaseStrobe_t          strobe,
  input  logic [NUM_PHASES-1:0] phase,
  input  rail_t                 srcA,
  input  rail_t                 srcB,
  input  gateOp_t               op,
  input  logic                  invA,
  input  logic                  invB,
  input  logic                  invY,
  output rail_t                 yOut,
  output logic                  errFlag
);
  rail_t gateOut;
  logic  gateIllegal;
  rail_t stageBus [STAGES];

  adp_rail_gate u_gate (
    .opA    (srcA),
    .opB    (srcB),
    .op     (op),
    .swapA  (invA),
    .swapB  (invB),
    .swapY  (invY),
    .result (gateOut),
    .illegal(gateIllegal)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    localparam int unsigned PH = k % NUM_PHASES;
    rail_t stageIn;
    rail_t q;

    if (k == 0) begin : g_head
      assign stageIn = gateOut;
    end else begin : g_link
      assign stageIn = stageBus[k-1];
    end

    always_ff @(posedge clk) begin
      if (rst) q <= RAIL_NULL;
      else if (strobe.loadEn[PH]) q <= stageIn;
      else if (strobe.holdEn[PH]) q <= q;
      else q <= RAIL_NULL;
    end

    assign stageBus[k] = q;

    // R4: nothing survives outside the stage's phase window
    p_window_r4 : assert property (@(posedge clk) disable iff (rst)
      !phase[PH] |-> q == RAIL_NULL);
    // R8: no stage ever carries both rails
    p_legal_r8 : assert property (@(posedge clk) disable iff (rst)
      !(q.r1 && q.r0));
    if (k > 0) begin : g_shift_chk
      // R4: each stage passes its predecessor's pulse on one tick later
      p_shift_r4 : assert property (@(posedge clk) disable iff (rst)
        strobe.loadEn[PH] |=> q == $past(stageBus[k-1]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) errFlag <= 1'b0;
    else errFlag <= strobe.loadEn[0] & gateIllegal;
  end

  assign yOut = stageBus[STAGES-1];

  // R8: the error pulse lasts a single cycle
  p_err_single_r8 : assert property (@(posedge clk) disable iff (rst)
    errFlag |=> !errFlag);
endmodule

// File: rtl/adiabatic_pipe.sv
module adiabatic_pipe
  import adp_pkg::*;
#(
  parameter int unsigned STAGES = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  aR1,
  input  logic                  aR0,
  input  logic                  bR1,
  input  logic                  bR0,
  input  logic                  opSel,
  input  logic                  invA,
  input  logic                  invB,
  input  logic                  invY,
  output logic [TICK_W-1:0]     tick,
  output logic [NUM_PHASES-1:0] phase,
  output logic                  yR1,
  output logic                  yR0,
  output logic                  errFlag
);
  phaseStrobe_t strobe;
  rail_t        yRail;
  rail_t        srcA;
  rail_t        srcB;

  assign srcA = '{r1: aR1, r0: aR0};
  assign srcB = '{r1: bR1, r0: bR0};

  adp_phase_ctrl u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .phase (phase),
    .strobe(strobe)
  );

  adp_datapath #(.STAGES(STAGES)) u_data (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .phase  (phase),
    .srcA   (srcA),
    .srcB   (srcB),
    .op     (gateOp_t'(opSel)),
    .invA   (invA),
    .invB   (invB),
    .invY   (invY),
    .yOut   (yRail),
    .errFlag(errFlag)
  );

  assign yR1 = yRail.r1;
  assign yR0 = yRail.r0;
endmodule

// File: tb/adiabatic_pipe_bench.sv
`timescale 1ns/1ps
module adiabatic_pipe_bench;
  localparam int N = 8;
  localparam int RING = 256;
  localparam int RUN_CYCLES = 700;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aR1 = 0, aR0 = 0, bR1 = 0, bR0 = 0, opSel = 0, invA = 0, invB = 0, invY = 0;
  logic [1:0] tick;
  logic [3:0] phase;
  logic yR1, yR0, errFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] expY [RING];
  logic       expErr [RING];
  string      expTag [RING];

  always #2.5 clk = ~clk;

  adiabatic_pipe #(.STAGES(N)) u_adiabatic_pipe (
    .clk(clk), .rst(rst), .aR1(aR1), .aR0(aR0), .bR1(bR1), .bR0(bR0),
    .opSel(opSel), .invA(invA), .invB(invB), .invY(invY),
    .tick(tick), .phase(phase), .yR1(yR1), .yR0(yR0), .errFlag(errFlag)
  );

  // logic-level reference: decode rails, compute, re-encode
  function automatic logic [1:0] refGate(logic [1:0] a, logic [1:0] b, logic op,
                                         logic ia, logic ib, logic iy);
    logic av, bv, y;
    if (a == 2'b11 || b == 2'b11 || a == 2'b00 || b == 2'b00) return 2'b00;
    av = (a == 2'b10) ^ ia;
    bv = (b == 2'b10) ^ ib;
    y  = op ? (av | bv) : (av & bv);
    y  = y ^ iy;
    return y ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [1:0] randRail();
    int r;
    r = int'($urandom % 16);
    if (r < 7) return 2'b10;
    if (r < 14) return 2'b01;
    if (r == 14) return 2'b00;
    return 2'b11;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  initial begin
    #(50000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seedv;
    seedv = $urandom(32'd2024);
    for (int i = 0; i < RING; i++) begin
      expY[i] = 2'b00;
      expErr[i] = 1'b0;
      expTag[i] = "R3 R4";
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "tick", int'(tick), 0);
    check("R1", "rails", int'({yR1, yR0}), 0);
    check("R1", "errFlag", int'(errFlag), 0);
    rst = 1'b0;

    for (int c = 0; c < RUN_CYCLES; c++) begin
      int slot, t, w;
      logic [3:0] expPh;
      logic [1:0] a, b, v;
      logic op, ia, ib, iy, bad, nul, rnd;
      string tag;

      if (c > 0) @(negedge clk);
      slot = c % RING;
      t = c % 4;
      for (int i = 0; i < 4; i++) expPh[i] = (t == i) || (t == ((i + 1) % 4));
      check("R2", "tick", int'(tick), t);
      check("R2", "phase", int'(phase), int'(expPh));
      check(expTag[slot], "rails", int'({yR1, yR0}), int'(expY[slot]));
      check("R8", "errFlag", int'(errFlag), int'(expErr[slot]));
      expY[slot] = 2'b00;
      expErr[slot] = 1'b0;
      expTag[slot] = "R3 R4";

      if (t == 3) begin
        w = c / 4;
        rnd = (w >= 20);
        if (w < 16) begin
          a = w[0] ? 2'b10 : 2'b01;
          b = w[1] ? 2'b10 : 2'b01;
          op = w[2];
          ia = w[3];
          ib = w[3];
          iy = w[3];
        end else if (w < 20) begin
          a = (w == 16) ? 2'b00 : (w == 18) ? 2'b11 : 2'b10;
          b = (w == 17) ? 2'b00 : (w == 19) ? 2'b11 : 2'b01;
          op = w[0];
          ia = 1'b0;
          ib = 1'b0;
          iy = 1'b0;
        end else begin
          a = randRail();
          b = randRail();
          op = 1'($urandom % 2);
          ia = 1'($urandom % 2);
          ib = 1'($urandom % 2);
          iy = 1'($urandom % 2);
        end
        bad = (a == 2'b11) || (b == 2'b11);
        nul = (a == 2'b00) || (b == 2'b00);
        if (bad) tag = "R8";
        else if (nul) tag = "R7";
        else if (ia | ib | iy) tag = "R6";
        else tag = "R5";
        if (rnd) tag = {"R9 ", tag};
        tag = {"R4 ", tag};
        v = refGate(a, b, op, ia, ib, iy);
        expY[(c + N) % RING] = v;
        expY[(c + N + 1) % RING] = v;
        expTag[(c + N) % RING] = tag;
        expTag[(c + N + 1) % RING] = tag;
        expErr[(c + 1) % RING] = bad;
      end else begin
        // R3: stimulus in ignored ticks, illegal pairs included
        a = 2'($urandom % 4);
        b = 2'($urandom % 4);
        op = 1'($urandom % 2);
        ia = 1'($urandom % 2);
        ib = 1'($urandom % 2);
        iy = 1'($urandom % 2);
      end
      {aR1, aR0} = a;
      {bR1, bR0} = b;
      opSel = op;
      invA = ia;
      invB = ib;
      invY = iy;
    end

    // R1: reset while waves are in flight
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", "tick after reset", int'(tick), 0);
    check("R1", "rails after reset", int'({yR1, yR0}), 0);
    check("R1", "errFlag after reset", int'(errFlag), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule